// File: doc/BRIEF.md
# D-PHY Clock Lane Sequencer

This block steers one D-PHY clock lane between its low-power stop state and high-speed clocking. It runs on the lane byte clock, and it counts every protocol phase in byte-clock periods. The timing comes from a packed phase word plus two separate 8-bit counts: one for the LP-01 request interval and one for the minimum clock run time before data. When the data lanes raise a request, the sequencer leaves LP-11. It drives LP-01 and then LP-00 on the low-power driver. It then hands over to the high-speed driver for HS-0 and starts toggling the clock. It grants the data lanes only once the pre-data run time has also elapsed.

When the request falls, the clock keeps running for the post count. That count is programmed to cover the data-lane trail time as well. The lane then holds HS-0 for the trail count and returns to LP-11 with stop reported. Each of the two analog drive enables can be forced from an input bit pair, which bypasses the state machine. A 4-bit status word reports bias readiness, stop, an externally supplied ultra-low-power flag, and high-speed activity.

Top module: `dphy_clklane_seq`

## Requirements
- R1: After reset the lane is in stop: status stop bit 1, low-power drive enable 1, high-speed drive enable 0, line levels dp=1 dn=1, grant 0, clock output 0.
- R2: Entry follows stop (dp,dn = 1,1) -> LP-01 (dp=0, dn=1) -> LP-00 (0,0), with the low-power driver enabled and the high-speed driver off. Then comes HS-0, with the high-speed driver on, the low-power driver off and the clock output 0. Then the clock toggles.
- R3: Phase word fields are prepare [31:24], zero [23:16], post [15:8] and trail [7:0]. The LP-01 phase lasts the LP-01 count. Each phase lasts its count in byte-clock cycles.
- R4: The grant rises only after the pre-data count has run with the clock toggling. The grant is first seen L+P+Z+R+1 cycles after the request is first sampled (each term is a phase length).
- R5: The clock output inverts on every byte-clock cycle while the clock runs (pre, granted and post phases).
- R6: When the request falls in the granted phase, the grant drops on the next cycle. The clock runs for the post count, then HS-0 is held for the trail count, then stop is reported Po+Tr+1 cycles after the fall.
- R7: A request is accepted only in stop. A request raised during exit neither shortens the post or trail phases nor skips stop, and stop lasts one cycle before LP-01 begins.
- R8: When a drive enable's force-select input is 1, that enable equals its force value in every state. When it is 0, the enable follows the state machine.
- R9: Status is {bias_ok, stop, ulps, hs_active}, bits [3:0] from most to least significant. hs_active reflects the state machine, not the forced enables.
- R10: A programmed count of zero lasts one cycle, the same as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_word_i | input | 32 | Packed prepare, zero, post and trail counts |
| lpx_cnt_i | input | 8 | LP-01 request interval count |
| pre_cnt_i | input | 8 | Minimum clock run time before grant |
| hs_req_i | input | 1 | Data-lane request for high-speed clock (level) |
| hs_gnt_o | output | 1 | Clock running and pre-data time met |
| bias_ok_i | input | 1 | Analog bias ready, reported in status |
| ulps_i | input | 1 | Ultra-low-power flag, reported in status |
| hs_force_sel_i | input | 1 | Force high-speed drive enable from hs_force_val_i |
| hs_force_val_i | input | 1 | Forced high-speed drive enable value |
| lp_force_sel_i | input | 1 | Force low-power drive enable from lp_force_val_i |
| lp_force_val_i | input | 1 | Forced low-power drive enable value |
| hs_drv_en_o | output | 1 | High-speed driver enable |
| lp_drv_en_o | output | 1 | Low-power driver enable |
| lp_dp_o | output | 1 | Low-power level on the positive line |
| lp_dn_o | output | 1 | Low-power level on the negative line |
| hs_clk_o | output | 1 | High-speed clock bit toward the serializer |
| status_o | output | 4 | {bias_ok, stop, ulps, hs_active} |

## Verification
Every phase transition lands on a byte-clock edge. The grant is therefore due exactly L+P+Z+R+1 sampled cycles after a request first appears, and stop is due Po+Tr+1 cycles after the request falls. The driver pushes these two figures, computed from the programmed counts with zero raised to one, into a queue. The monitor counts falling-edge samples from the request change until the grant or stop is seen, and compares the count with the queued value. Line levels, enables, clock toggling and status are checked sample by sample in a directed run whose phase boundaries are known cycle by cycle. Forced enables are combinational and are checked in the sample after the force inputs change.

// File: rtl/clklane_pkg.sv
package clklane_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_LPX   = 3'd1,
    ST_PREP  = 3'd2,
    ST_ZERO  = 3'd3,
    ST_PRE   = 3'd4,
    ST_RUN   = 3'd5,
    ST_POST  = 3'd6,
    ST_TRAIL = 3'd7
  } lane_state_e;

  localparam int unsigned ENA_NUM = 2;
  localparam int unsigned ENA_HS  = 0;
  localparam int unsigned ENA_LP  = 1;
  localparam int unsigned STS_W   = 4;
endpackage

// File: rtl/clklane_phase_timer.sv
module clklane_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // A phase of N lasts max(N,1) cycles: load N-1, zero floors at zero.
  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = (count_i == '0) ? '0 : count_i - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R10: a zero count expires after a single cycle
  a_r10_zero_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && count_i == '0) |=> expired_o);
  // R3: the counter steps down by one per byte cycle
  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/clklane_fsm.sv
module clklane_fsm
  import clklane_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          expired_i,
  input  logic [CW-1:0] lpx_cnt_i,
  input  logic [CW-1:0] prep_cnt_i,
  input  logic [CW-1:0] zero_cnt_i,
  input  logic [CW-1:0] pre_cnt_i,
  input  logic [CW-1:0] post_cnt_i,
  input  logic [CW-1:0] trail_cnt_i,
  output logic          load_o,
  output logic [CW-1:0] load_cnt_o,
  output logic          hs_en_o,
  output logic          lp_en_o,
  output logic          lp_dp_o,
  output logic          lp_dn_o,
  output logic          gnt_o,
  output logic          hs_clk_o,
  output logic          stop_o
);
  lane_state_e state_q, state_d;
  logic        tog_q, tog_d;
  logic        running;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_STOP:  if (req_i)     state_d = ST_LPX;
      ST_LPX:   if (expired_i) state_d = ST_PREP;
      ST_PREP:  if (expired_i) state_d = ST_ZERO;
      ST_ZERO:  if (expired_i) state_d = ST_PRE;
      ST_PRE:   if (expired_i) state_d = req_i ? ST_RUN : ST_POST;
      ST_RUN:   if (!req_i)    state_d = ST_POST;
      ST_POST:  if (expired_i) state_d = ST_TRAIL;
      ST_TRAIL: if (expired_i) state_d = ST_STOP;
      default:                 state_d = ST_STOP;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_LPX:   load_cnt_o = lpx_cnt_i;
      ST_PREP:  load_cnt_o = prep_cnt_i;
      ST_ZERO:  load_cnt_o = zero_cnt_i;
      ST_PRE:   load_cnt_o = pre_cnt_i;
      ST_POST:  load_cnt_o = post_cnt_i;
      ST_TRAIL: load_cnt_o = trail_cnt_i;
      default:  load_cnt_o = '0;
    endcase
  end

  assign running = (state_q == ST_PRE) || (state_q == ST_RUN) || (state_q == ST_POST);
  assign tog_d   = running ? ~tog_q : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOP;
      tog_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tog_q   <= tog_d;
    end
  end

  assign stop_o   = (state_q == ST_STOP);
  assign lp_en_o  = (state_q == ST_STOP) || (state_q == ST_LPX) || (state_q == ST_PREP);
  assign hs_en_o  = !lp_en_o;
  assign lp_dp_o  = (state_q == ST_STOP);
  assign lp_dn_o  = (state_q == ST_STOP) || (state_q == ST_LPX);
  assign gnt_o    = (state_q == ST_RUN);
  assign hs_clk_o = tog_q & running;

  // R2: LP-00 is reached only through LP-01
  a_r2_prep_after_lpx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREP) |-> ($past(state_q) inside {ST_LPX, ST_PREP}));
  // R2: HS-0 is reached only through LP-00
  a_r2_zero_after_prep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO) |-> ($past(state_q) inside {ST_PREP, ST_ZERO}));
  // R4: grant rises only out of the pre-data phase
  a_r4_gnt_after_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_o) |-> ($past(state_q) == ST_PRE));
  // R5: the clock output inverts each cycle while granted
  a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> (hs_clk_o != $past(hs_clk_o)));
  // R6: stop is re-entered only from trail
  a_r6_stop_from_trail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && $past(state_q) != ST_STOP) |-> ($past(state_q) == ST_TRAIL));
  // R7: LP-01 is entered only from stop
  a_r7_entry_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LPX && $past(state_q) != ST_LPX) |-> ($past(state_q) == ST_STOP));
endmodule

// File: rtl/clklane_override.sv
module clklane_override #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] fsm_i,
  output logic [N-1:0] en_o
);
  for (genvar i = 0; i < N; i++) begin : g_ena
    assign en_o[i] = sel_i[i] ? val_i[i] : fsm_i[i];
  end
endmodule

// File: rtl/dphy_clklane_seq.sv
module dphy_clklane_seq
  import clklane_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4*CW-1:0] phase_word_i,
  input  logic [CW-1:0]   lpx_cnt_i,
  input  logic [CW-1:0]   pre_cnt_i,
  input  logic            hs_req_i,
  output logic            hs_gnt_o,
  input  logic            bias_ok_i,
  input  logic            ulps_i,
  input  logic            hs_force_sel_i,
  input  logic            hs_force_val_i,
  input  logic            lp_force_sel_i,
  input  logic            lp_force_val_i,
  output logic            hs_drv_en_o,
  output logic            lp_drv_en_o,
  output logic            lp_dp_o,
  output logic            lp_dn_o,
  output logic            hs_clk_o,
  output logic [3:0]      status_o
);
  logic          rst_meta, rst_n;
  logic          load, expired, fsm_hs, fsm_lp, stop;
  logic [CW-1:0] load_cnt;
  logic [ENA_NUM-1:0] f_sel, f_val, f_fsm, f_out;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  clklane_phase_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .load_i    (load),
    .count_i   (load_cnt),
    .expired_o (expired)
  );

  clklane_fsm #(.CW(CW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .req_i       (hs_req_i),
    .expired_i   (expired),
    .lpx_cnt_i   (lpx_cnt_i),
    .prep_cnt_i  (phase_word_i[4*CW-1:3*CW]),
    .zero_cnt_i  (phase_word_i[3*CW-1:2*CW]),
    .pre_cnt_i   (pre_cnt_i),
    .post_cnt_i  (phase_word_i[2*CW-1:CW]),
    .trail_cnt_i (phase_word_i[CW-1:0]),
    .load_o      (load),
    .load_cnt_o  (load_cnt),
    .hs_en_o     (fsm_hs),
    .lp_en_o     (fsm_lp),
    .lp_dp_o     (lp_dp_o),
    .lp_dn_o     (lp_dn_o),
    .gnt_o       (hs_gnt_o),
    .hs_clk_o    (hs_clk_o),
    .stop_o      (stop)
  );

  assign f_sel[ENA_HS] = hs_force_sel_i;
  assign f_sel[ENA_LP] = lp_force_sel_i;
  assign f_val[ENA_HS] = hs_force_val_i;
  assign f_val[ENA_LP] = lp_force_val_i;
  assign f_fsm[ENA_HS] = fsm_hs;
  assign f_fsm[ENA_LP] = fsm_lp;

  clklane_override #(.N(ENA_NUM)) u_ovr (
    .sel_i (f_sel),
    .val_i (f_val),
    .fsm_i (f_fsm),
    .en_o  (f_out)
  );

  assign hs_drv_en_o = f_out[ENA_HS];
  assign lp_drv_en_o = f_out[ENA_LP];
  assign status_o    = {bias_ok_i, stop, ulps_i, fsm_hs};

  // R1: the grant is never up while stop is reported
  a_r1_no_gnt_in_stop: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(hs_gnt_o && stop));
  // R6: once granted, the lane passes through post before stop
  a_r6_gnt_fall_no_stop: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(hs_gnt_o) |-> !stop);
endmodule

// File: tb/dphy_clklane_seq_test.sv
module dphy_clklane_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] phase_word = '0;
  logic [7:0]  lpx_cnt = '0;
  logic [7:0]  pre_cnt = '0;
  logic        req = 1'b0;
  logic        bias_ok = 1'b1;
  logic        ulps = 1'b0;
  logic        hs_sel = 1'b0, hs_val = 1'b0, lp_sel = 1'b0, lp_val = 1'b0;
  logic        gnt, hs_en, lp_en, dp, dn, hs_clk;
  logic [3:0]  status;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit mon_on = 1'b0;
  bit req_seen = 1'b0;
  int mon_phase = 0;
  int ecnt = 0;
  int xcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dphy_clklane_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_word_i(phase_word),
    .lpx_cnt_i(lpx_cnt), .pre_cnt_i(pre_cnt), .hs_req_i(req), .hs_gnt_o(gnt),
    .bias_ok_i(bias_ok), .ulps_i(ulps),
    .hs_force_sel_i(hs_sel), .hs_force_val_i(hs_val),
    .lp_force_sel_i(lp_sel), .lp_force_val_i(lp_val),
    .hs_drv_en_o(hs_en), .lp_drv_en_o(lp_en), .lp_dp_o(dp), .lp_dn_o(dn),
    .hs_clk_o(hs_clk), .status_o(status)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int one_min(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic drive_at(input logic v);
    @(posedge clk); #2 req = v;
  endtask

  // scoreboard driver: expected latencies go into the queue first
  task automatic burst(input int l, input int p, input int z, input int r,
                       input int po, input int tr, input int run);
    lpx_cnt    = 8'(l);
    pre_cnt    = 8'(r);
    phase_word = {8'(p), 8'(z), 8'(po), 8'(tr)};
    exp_q.push_back(one_min(l) + one_min(p) + one_min(z) + one_min(r) + 1);
    exp_q.push_back(one_min(po) + one_min(tr) + 1);
    drive_at(1'b1);
    do @(negedge clk); while (!gnt);
    repeat (run) @(negedge clk);
    drive_at(1'b0);
    do @(negedge clk); while (!status[2]);
    repeat (3) @(negedge clk);
  endtask

  // monitor: counts samples from request edge to grant and to stop
  always @(negedge clk) begin
    if (mon_on) begin
      if (req && !req_seen) begin
        req_seen = 1'b1; ecnt = 0; mon_phase = 1;
      end else if (mon_phase == 1) begin
        ecnt++;
        if (gnt) begin
          check("R3 R4 R10 entry latency", ecnt, (exp_q.size() > 0) ? exp_q.pop_front() : -1);
          mon_phase = 2;
        end
      end
      if (mon_phase == 2 && !req) begin
        mon_phase = 3; xcnt = 0;
      end else if (mon_phase == 3) begin
        xcnt++;
        if (status[2]) begin
          check("R6 R10 exit latency", xcnt, (exp_q.size() > 0) ? exp_q.pop_front() : -1);
          mon_phase = 0; req_seen = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R0 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 stop", status[2], 1);
    check("R1 lp_en", lp_en, 1);
    check("R1 hs_en", hs_en, 0);
    check("R1 dp", dp, 1);
    check("R1 dn", dn, 1);
    check("R1 gnt", gnt, 0);
    check("R1 hs_clk", hs_clk, 0);
    check("R9 status idle", status, 4'b1100);

    // R8 forcing in stop
    @(posedge clk); #2 hs_sel = 1; hs_val = 1; lp_sel = 1; lp_val = 0;
    @(negedge clk);
    check("R8 hs forced on", hs_en, 1);
    check("R8 lp forced off", lp_en, 0);
    check("R9 hs_active unaffected by force", status[0], 0);
    @(posedge clk); #2 hs_sel = 0; lp_sel = 0; ulps = 1;
    @(negedge clk);
    check("R8 hs released", hs_en, 0);
    check("R8 lp released", lp_en, 1);
    check("R9 ulps flag", status, 4'b1110);
    @(posedge clk); #2 ulps = 0;

    // directed entry: L=3 P=2 Z=2 R=2, post 3, trail 2
    lpx_cnt = 8'd3; pre_cnt = 8'd2; phase_word = {8'd2, 8'd2, 8'd3, 8'd2};
    drive_at(1'b1);
    @(negedge clk);
    check("R2 still stop c0", {dp, dn}, 2'b11);
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      if (c <= 3) begin
        check("R2 R3 LP-01 levels", {dp, dn}, 2'b01);
        check("R2 LP-01 enables", {hs_en, lp_en}, 2'b01);
      end else if (c <= 5) begin
        check("R2 R3 LP-00 levels", {dp, dn}, 2'b00);
        check("R2 LP-00 enables", {hs_en, lp_en}, 2'b01);
      end else if (c <= 7) begin
        check("R2 R3 HS-0 enables", {hs_en, lp_en}, 2'b10);
        check("R2 HS-0 clock low", hs_clk, 0);
      end else begin
        check("R4 no grant during pre", gnt, 0);
        check("R5 pre clock", hs_clk, (c == 8) ? 0 : 1);
      end
    end
    @(negedge clk);
    check("R4 grant at L+P+Z+R+1", gnt, 1);
    check("R9 status running", status, 4'b1001);
    prev = hs_clk;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R5 toggle while granted", hs_clk, 1 - prev);
      prev = hs_clk;
    end
    @(posedge clk); #2 hs_sel = 1; hs_val = 0;
    @(negedge clk);
    check("R8 hs forced off in run", hs_en, 0);
    check("R9 hs_active follows fsm", status[0], 1);
    @(posedge clk); #2 hs_sel = 0;

    // directed exit with a request re-raised during post (R7)
    drive_at(1'b0);
    @(negedge clk);
    check("R6 grant held until edge", gnt, 1);
    drive_at(1'b1);
    for (int c = 1; c <= 7; c++) begin
      @(negedge clk);
      if (c <= 3) begin
        check("R6 post grant low", gnt, 0);
        check("R7 no early stop in post", status[2], 0);
        check("R6 post clock running", hs_en, 1);
      end else if (c <= 5) begin
        check("R6 trail HS-0", {hs_en, hs_clk}, 2'b10);
        check("R7 no early stop in trail", status[2], 0);
      end else if (c == 6) begin
        check("R7 stop shown once", status[2], 1);
        check("R6 stop levels", {dp, dn, lp_en}, 3'b111);
      end else begin
        check("R7 re-entry to LP-01", {status[2], dp, dn}, 3'b001);
      end
    end
    do @(negedge clk); while (!gnt);
    drive_at(1'b0);
    do @(negedge clk); while (!status[2]);
    repeat (3) @(negedge clk);

    // scoreboard bursts
    mon_on = 1'b1;
    burst(1, 1, 1, 1, 1, 1, 2);
    burst(0, 0, 0, 0, 0, 0, 1);      // R10 zero counts
    burst(5, 3, 7, 4, 6, 2, 5);
    burst(2, 9, 1, 12, 0, 3, 0);
    burst(20, 30, 40, 8, 25, 15, 7);
    burst(255, 1, 2, 3, 4, 255, 2);
    mon_on = 1'b0;
    check("R4 R6 queue drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule